// File: doc/BRIEF.md
# Segment-Table Address Translator

This block turns a 14-bit logical address into a 16-bit physical address through a table of four segment entries. The two upper address bits pick the entry and the low twelve bits are the offset into the segment. Each entry holds a 16-bit base, a 12-bit bound and a 2-bit permission field. In a single cycle the block adds the offset to the base and, alongside that addition, compares the offset against the bound and the access kind against the permissions. The result and any fault are registered and presented one cycle after the request.

A host loads the table through a simple write port that gives an entry index plus its base, bound and permissions. After reset every entry grants no access, so nothing translates until the table has been loaded. A requester raises a valid strobe with the address and a write flag, then reads the done strobe, the physical address and two fault flags on the following cycle.

Top module: `segx_translator`

## Requirements
- R1: Logical bits [13:12] select the segment and bits [11:0] form the offset. The physical address is the selected base plus the zero-extended offset, taken modulo 2^16.
- R2: `rsp_done` is high in exactly the cycle after a cycle with `req_valid` high, and is low otherwise. `rsp_paddr` and both fault flags keep their values between responses.
- R3: The permission field uses bit 1 as the read grant and bit 0 as the write grant. Any access (read or write) to a segment whose read grant is 0 raises `rsp_prot_fault`. This covers encodings 00 and 01.
- R4: A write (`req_write`=1) to a segment whose write grant is 0 raises `rsp_prot_fault`. A read of a segment with permission 10 completes without a fault.
- R5: An offset strictly greater than the segment's bound raises `rsp_bound_fault`. An offset equal to the bound is legal.
- R6: When a protection fault and a bounds fault both apply, only `rsp_prot_fault` is set.
- R7: On any fault, `rsp_paddr` is 0.
- R8: A table write updates entry `tbl_idx` from the next cycle onward. A request in the same cycle as the write still sees the old entry.
- R9: After reset, `rsp_done` is low and every entry has permission 00, so any access faults on protection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | 1 = write access, 0 = read access |
| req_laddr | input | 14 | Logical address |
| tbl_we | input | 1 | Table entry write enable |
| tbl_idx | input | 2 | Entry to write |
| tbl_base | input | 16 | Base for the entry |
| tbl_bound | input | 12 | Highest legal offset for the entry |
| tbl_perm | input | 2 | Permissions: bit 1 read, bit 0 write |
| rsp_done | output | 1 | Response valid, one cycle after request |
| rsp_paddr | output | 16 | Physical address, 0 on fault |
| rsp_prot_fault | output | 1 | Permission violation |
| rsp_bound_fault | output | 1 | Offset beyond bound |

## Verification
The bench aims at the exact bound edge, where offset equal to the bound passes and bound plus one fails. A comparator built with greater-or-equal would reject the last legal byte. It drives a write that is both out of bounds and forbidden, which catches a design that reports both faults or lets the bounds fault win. It covers the write-only encoding, which a design that only checks the write grant on writes would let reads through. It also tests a base near the top of the space to check that the sum wraps, and a request that lands in the same cycle as a table write to that entry, which exposes a bypass that would use the new entry too early.

// File: rtl/segx_pkg.sv
package segx_pkg;
  localparam int SEG_W  = 2;
  localparam int OFF_W  = 12;
  localparam int LA_W   = SEG_W + OFF_W;
  localparam int PA_W   = 16;
  localparam int NSEG   = 1 << SEG_W;
  localparam int PERM_W = 2;
  localparam int PERM_RD = 1;
  localparam int PERM_WR = 0;

  typedef struct packed {
    logic [PA_W-1:0]   base;
    logic [OFF_W-1:0]  bound;
    logic [PERM_W-1:0] perm;
  } seg_entry_t;
endpackage

// File: rtl/segx_rst_sync.sv
module segx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_q_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_q_n = sync_q[STAGES-1];
endmodule

// File: rtl/segx_table.sv
module segx_table
  import segx_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_q_n,
  input  logic                    wr_en,
  input  logic [SEG_W-1:0]        wr_idx,
  input  seg_entry_t              wr_entry,
  input  logic [SEG_W-1:0]        rd_idx,
  output seg_entry_t              rd_entry
);
  seg_entry_t [NSEG-1:0] ent_q;
  seg_entry_t [NSEG-1:0] ent_d;

  for (genvar g = 0; g < NSEG; g++) begin : g_ent
    logic hit;
    assign hit = wr_en && (wr_idx == SEG_W'(g));

    always_comb begin
      ent_d[g] = ent_q[g];
      if (hit) ent_d[g] = wr_entry;
    end

    always_ff @(posedge clk or negedge rst_q_n) begin
      if (!rst_q_n) ent_q[g] <= '0;
      else if (hit) ent_q[g] <= ent_d[g];
    end
  end

  assign rd_entry = ent_q[rd_idx];

  // R8: without a write the table content does not move
  a_r8_table_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !wr_en |=> $stable(ent_q));
endmodule

// File: rtl/segx_check.sv
module segx_check
  import segx_pkg::*;
(
  input  seg_entry_t        entry,
  input  logic [OFF_W-1:0]  offset,
  input  logic              is_write,
  output logic [PA_W-1:0]   paddr,
  output logic              prot_fault,
  output logic              bound_fault
);
  logic [PA_W-1:0] sum;
  logic            over;
  logic            deny;

  always_comb begin
    // adder and comparator sit side by side, neither waits on the other
    sum  = entry.base + PA_W'(offset);
    over = offset > entry.bound;
    deny = !entry.perm[PERM_RD] || (is_write && !entry.perm[PERM_WR]);
    prot_fault  = deny;
    bound_fault = over && !deny;
    paddr       = (deny || over) ? '0 : sum;
  end
endmodule

// File: rtl/segx_translator.sv
module segx_translator
  import segx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [LA_W-1:0]   req_laddr,
  input  logic              tbl_we,
  input  logic [SEG_W-1:0]  tbl_idx,
  input  logic [PA_W-1:0]   tbl_base,
  input  logic [OFF_W-1:0]  tbl_bound,
  input  logic [PERM_W-1:0] tbl_perm,
  output logic              rsp_done,
  output logic [PA_W-1:0]   rsp_paddr,
  output logic              rsp_prot_fault,
  output logic              rsp_bound_fault
);
  logic            rst_q_n;
  seg_entry_t      wr_entry;
  seg_entry_t      sel;
  logic [PA_W-1:0] c_paddr;
  logic            c_pf;
  logic            c_bf;

  logic            done_d, pf_d, bf_d;
  logic [PA_W-1:0] paddr_d;

  segx_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_q_n(rst_q_n));

  assign wr_entry = '{base: tbl_base, bound: tbl_bound, perm: tbl_perm};

  segx_table u_tbl (
    .clk(clk), .rst_q_n(rst_q_n),
    .wr_en(tbl_we), .wr_idx(tbl_idx), .wr_entry(wr_entry),
    .rd_idx(req_laddr[LA_W-1:OFF_W]), .rd_entry(sel));

  segx_check u_chk (
    .entry(sel), .offset(req_laddr[OFF_W-1:0]), .is_write(req_write),
    .paddr(c_paddr), .prot_fault(c_pf), .bound_fault(c_bf));

  always_comb begin
    done_d  = req_valid;
    paddr_d = rsp_paddr;
    pf_d    = rsp_prot_fault;
    bf_d    = rsp_bound_fault;
    if (req_valid) begin
      paddr_d = c_paddr;
      pf_d    = c_pf;
      bf_d    = c_bf;
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_done        <= 1'b0;
      rsp_paddr       <= '0;
      rsp_prot_fault  <= 1'b0;
      rsp_bound_fault <= 1'b0;
    end else begin
      rsp_done <= done_d;
      if (req_valid) begin
        rsp_paddr       <= paddr_d;
        rsp_prot_fault  <= pf_d;
        rsp_bound_fault <= bf_d;
      end
    end
  end

  a_r2_done_follows: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid |=> rsp_done);
  a_r2_done_quiet: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> !rsp_done);
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_q_n)
    !req_valid |=> $stable(rsp_paddr) && $stable(rsp_prot_fault));
  a_r3_no_read_grant: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid && !sel.perm[PERM_RD] |=> rsp_prot_fault);
  a_r4_no_write_grant: assert property (@(posedge clk) disable iff (!rst_q_n)
    req_valid && req_write && !sel.perm[PERM_WR] |=> rsp_prot_fault);
  a_r6_single_fault: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done |-> !(rsp_prot_fault && rsp_bound_fault));
  a_r7_zero_on_fault: assert property (@(posedge clk) disable iff (!rst_q_n)
    rsp_done && (rsp_prot_fault || rsp_bound_fault) |-> rsp_paddr == '0);
endmodule

// File: tb/segx_translator_bench.sv
module segx_translator_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [13:0] req_laddr = '0;
  logic        tbl_we = 1'b0;
  logic [1:0]  tbl_idx = '0;
  logic [15:0] tbl_base = '0;
  logic [11:0] tbl_bound = '0;
  logic [1:0]  tbl_perm = '0;
  logic        rsp_done, rsp_prot_fault, rsp_bound_fault;
  logic [15:0] rsp_paddr;

  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  segx_translator u_segx_translator (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_laddr(req_laddr), .tbl_we(tbl_we), .tbl_idx(tbl_idx),
    .tbl_base(tbl_base), .tbl_bound(tbl_bound), .tbl_perm(tbl_perm),
    .rsp_done(rsp_done), .rsp_paddr(rsp_paddr),
    .rsp_prot_fault(rsp_prot_fault), .rsp_bound_fault(rsp_bound_fault));

  // {laddr, write, paddr, prot_fault, bound_fault}
  localparam logic [32:0] VEC [NV] = '{
    {14'h0240, 1'b0, 16'h4240, 1'b0, 1'b0},  // R1 base+offset
    {14'h0240, 1'b1, 16'h0000, 1'b1, 1'b0},  // R4 write to read-only
    {14'h06FF, 1'b0, 16'h46FF, 1'b0, 1'b0},  // R5 offset == bound
    {14'h0700, 1'b0, 16'h0000, 1'b0, 1'b1},  // R5 bound+1
    {14'h0700, 1'b1, 16'h0000, 1'b1, 1'b0},  // R6 both apply
    {14'h1108, 1'b0, 16'h0108, 1'b0, 1'b0},  // R1 seg1 read
    {14'h1108, 1'b1, 16'h0108, 1'b0, 1'b0},  // R4 write on rw
    {14'h1500, 1'b0, 16'h0000, 1'b0, 1'b1},  // R5
    {14'h265C, 1'b0, 16'h365C, 1'b0, 1'b0},  // R1 seg2
    {14'h2FFF, 1'b1, 16'h3FFF, 1'b0, 1'b0},  // R5 max offset
    {14'h3002, 1'b0, 16'h0000, 1'b1, 1'b0},  // R3 perm 00
    {14'h3000, 1'b1, 16'h0000, 1'b1, 1'b0}   // R3 perm 00, in bounds
  };

  task automatic check(input logic ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] idx, input logic [15:0] b,
                      input logic [11:0] bd, input logic [1:0] p);
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = idx; tbl_base = b; tbl_bound = bd; tbl_perm = p;
    @(negedge clk);
    tbl_we = 1'b0;
  endtask

  task automatic xlate(input logic [13:0] la, input logic wr, input logic [15:0] ep,
                       input logic epf, input logic ebf, input string tag);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_laddr = la;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_done, {tag, " done"}, 32'(rsp_done), 32'd1);
    check({rsp_paddr, rsp_prot_fault, rsp_bound_fault} == {ep, epf, ebf}, tag,
          {14'd0, rsp_paddr, rsp_prot_fault, rsp_bound_fault}, {14'd0, ep, epf, ebf});
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R9 reset state
    check(!rsp_done, "R9 done low", 32'(rsp_done), 32'd0);
    xlate(14'h0010, 1'b0, 16'h0000, 1'b1, 1'b0, "R9 empty table");
    @(negedge clk);
    check(!rsp_done, "R2 done one pulse", 32'(rsp_done), 32'd0);
    check(rsp_prot_fault, "R2 hold fault", 32'(rsp_prot_fault), 32'd1);

    load(2'd0, 16'h4000, 12'h6FF, 2'b10);
    load(2'd1, 16'h0000, 12'h4FF, 2'b11);
    load(2'd2, 16'h3000, 12'hFFF, 2'b11);
    load(2'd3, 16'h0000, 12'h000, 2'b00);

    for (int i = 0; i < NV; i++)
      xlate(VEC[i][32:19], VEC[i][18], VEC[i][17:2], VEC[i][1], VEC[i][0],
            $sformatf("vec%0d", i));

    // R1 sum wraps modulo 2^16
    load(2'd3, 16'hFFF0, 12'hFFF, 2'b11);
    xlate(14'h3020, 1'b0, 16'h0010, 1'b0, 1'b0, "R1 wrap");

    // R3 write-only encoding 01 still faults on both kinds
    load(2'd1, 16'h0800, 12'hFFF, 2'b01);
    xlate(14'h1004, 1'b0, 16'h0000, 1'b1, 1'b0, "R3 perm01 read");
    xlate(14'h1004, 1'b1, 16'h0000, 1'b1, 1'b0, "R3 perm01 write");

    // R8 request in same cycle as write uses old entry; next uses new
    @(negedge clk);
    tbl_we = 1'b1; tbl_idx = 2'd2; tbl_base = 16'h8000; tbl_bound = 12'hFFF; tbl_perm = 2'b11;
    req_valid = 1'b1; req_write = 1'b0; req_laddr = 14'h2010;
    @(negedge clk);
    tbl_we = 1'b0; req_valid = 1'b0;
    check(rsp_done && rsp_paddr == 16'h3010, "R8 old entry", 32'(rsp_paddr), 32'h3010);
    xlate(14'h2010, 1'b0, 16'h8010, 1'b0, 1'b0, "R8 new entry");

    // R2 outputs hold while idle
    repeat (3) @(negedge clk);
    check(!rsp_done && rsp_paddr == 16'h8010, "R2 idle hold", 32'(rsp_paddr), 32'h8010);

    // R9 async reset clears the table again
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(!rsp_done && rsp_paddr == 16'h0, "R9 reset outputs", 32'(rsp_paddr), 32'h0);
    xlate(14'h2010, 1'b0, 16'h0000, 1'b1, 1'b0, "R9 table cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule